// File: doc/BRIEF.md
# Type-C Lane Routing Controller

This block sits in front of the switch fabric of a Type-C alternate-mode crosspoint. It turns two mode pins and a plug-orientation pin into registered routing selects. There is one select for each connector-side lane (TX1, RX1, TX2, RX2), one for the source of the USB upstream receive pair, and one for the AUX-to-sideband mapping. A power-down flag completes the outputs. A port-policy controller drives the pins. The switch fabric uses the selects to close the matching analog paths.

After reset the block forces USB-only routing, whatever the mode pins show. Control pin 0 must then go low, high and low again before the live pin decode takes over. The AUX path follows control pin 1: it is mapped while that pin is high. It is opened only after the pin has stayed low for longer than a set number of clock cycles, so a brief low does not disturb the sideband. All pins pass through synchronisers, and every output comes from a register.

Top module: `tcx_lane_router`

## Requirements
- R1: The mode comes from {control pin 1, control pin 0}. 00 is power-down, 01 is USB only, 10 is four DisplayPort lanes and 11 is USB plus two DisplayPort lanes. A lane select code is 0 for none, 1 for USB transmit, or 4+n for DisplayPort lane n. Codes 2 and 3 never appear, and code 1 never appears on an RX lane. The upstream-receive select is 0 for none, 1 for connector RX1 and 2 for connector RX2.
- R2: In power-down, the power-down output is 1, every lane select and the upstream-receive select are 0, and the flip pin changes none of them.
- R3: USB only, flip low: TX1 is 1 and the upstream-receive select is 1. Flip high: TX2 is 1 and the upstream-receive select is 2. All other lanes are 0.
- R4: Four-lane DisplayPort, flip low: RX2, TX2, TX1 and RX1 carry DP lanes 0, 1, 2 and 3 (codes 4, 5, 6, 7). Flip high: RX1, TX1, TX2 and RX2 carry them. The upstream-receive select is 0.
- R5: USB plus two DisplayPort lanes, flip low: TX1 is 1, the upstream-receive select is 1, RX2 is 4 and TX2 is 5. Flip high: TX2 is 1, the upstream-receive select is 2, RX1 is 4 and TX1 is 5.
- R6: While control pin 1 is high, the AUX select is 1 (positive to SBU1, negative to SBU2) with flip low, and 2 (crossed) with flip high.
- R7: The AUX select becomes 0 (open) only after control pin 1 has been low for more than AUX_OPEN_CYCLES clock cycles. A shorter low keeps the previous mapping.
- R8: After reset, the routing is USB only, oriented by the flip pin, whatever the mode pins show. This holds until control pin 0 is seen low, then high, then low again, where control pin 0 counts as low at reset. An unfinished sequence keeps the forced mode.
- R9: While reset is held, TX1 is 1, the upstream-receive select is 1, the other lanes are 0, the AUX select is 0 and the power-down output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl1_i | input | 1 | Mode pin 1 (DisplayPort enable); also drives the AUX path |
| ctl0_i | input | 1 | Mode pin 0 (USB enable); also carries the release pulse |
| flip_i | input | 1 | Plug orientation |
| tx1_sel_o | output | 3 | Source select for connector TX1 |
| rx1_sel_o | output | 3 | Source select for connector RX1 |
| tx2_sel_o | output | 3 | Source select for connector TX2 |
| rx2_sel_o | output | 3 | Source select for connector RX2 |
| usrx_sel_o | output | 2 | Connector lane that feeds the USB upstream receive pair |
| aux_sel_o | output | 2 | AUX-to-sideband mapping |
| pwrdn_o | output | 1 | Power-down request |

## Verification
Some properties hold on every cycle, and the assertions check those. Power-down leaves every path unrouted. No lane ever carries an illegal code, and no DisplayPort lane is driven onto two connector lanes. The USB transmit and receive pairs always sit on the same plug side. Nothing but USB routing appears before release. The AUX mapping follows control pin 1 while it is high and never opens before the low-time window has passed. Only the bench scenarios can show the rest: that every pin and flip combination yields the exact lane table, that a release sequence left unfinished keeps the forced mode, and that lows just shorter and just longer than the window give different AUX outcomes.

// File: rtl/tcx_pkg.sv
package tcx_pkg;

    localparam int LANE_CODE_W    = 3;
    localparam int NUM_CONN_LANES = 4;

    // connector lane positions inside the route vector
    localparam logic [1:0] LANE_TX1 = 2'd0;
    localparam logic [1:0] LANE_RX1 = 2'd1;
    localparam logic [1:0] LANE_TX2 = 2'd2;
    localparam logic [1:0] LANE_RX2 = 2'd3;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_USB     = 2'b01,
        MODE_DP4     = 2'b10,
        MODE_USB_DP2 = 2'b11
    } xbar_mode_e;

    typedef enum logic [LANE_CODE_W-1:0] {
        LS_NONE   = 3'd0,
        LS_USB_TX = 3'd1,
        LS_DP0    = 3'd4,
        LS_DP1    = 3'd5,
        LS_DP2    = 3'd6,
        LS_DP3    = 3'd7
    } lane_src_e;

    typedef enum logic [1:0] {
        UR_NONE = 2'd0,
        UR_RX1  = 2'd1,
        UR_RX2  = 2'd2
    } usrx_src_e;

    typedef enum logic [1:0] {
        AUX_OPEN     = 2'd0,
        AUX_STRAIGHT = 2'd1,
        AUX_CROSSED  = 2'd2
    } aux_map_e;

    typedef enum logic [1:0] {
        BG_ARM  = 2'd0,
        BG_LOW  = 2'd1,
        BG_HIGH = 2'd2,
        BG_DONE = 2'd3
    } boot_phase_e;

    typedef struct packed {
        logic [NUM_CONN_LANES-1:0][LANE_CODE_W-1:0] lane;
        usrx_src_e                                   usrx;
        logic                                        pwrdn;
    } route_t;

    // DisplayPort lane n -> lane select code
    function automatic logic [LANE_CODE_W-1:0] dp_code(input logic [1:0] n);
        return {1'b1, n};
    endfunction

    // mode + orientation -> per-lane routing
    function automatic route_t decode_route(input xbar_mode_e mode, input logic flip);
        route_t     r;
        logic [1:0] usb_tx, usb_rx, alt_tx, alt_rx;
        r      = '0;
        usb_tx = flip ? LANE_TX2 : LANE_TX1;
        usb_rx = flip ? LANE_RX2 : LANE_RX1;
        alt_tx = flip ? LANE_TX1 : LANE_TX2;
        alt_rx = flip ? LANE_RX1 : LANE_RX2;
        case (mode)
            MODE_OFF: begin
                r.pwrdn = 1'b1;
            end
            MODE_USB: begin
                r.lane[usb_tx] = LS_USB_TX;
                r.usrx         = flip ? UR_RX2 : UR_RX1;
            end
            MODE_DP4: begin
                r.lane[alt_rx] = dp_code(2'd0);
                r.lane[alt_tx] = dp_code(2'd1);
                r.lane[usb_tx] = dp_code(2'd2);
                r.lane[usb_rx] = dp_code(2'd3);
            end
            default: begin
                r.lane[usb_tx] = LS_USB_TX;
                r.usrx         = flip ? UR_RX2 : UR_RX1;
                r.lane[alt_rx] = dp_code(2'd0);
                r.lane[alt_tx] = dp_code(2'd1);
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tcx_sync.sv
module tcx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/tcx_boot_gate.sv
module tcx_boot_gate
    import tcx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ctl0_s,
    output logic boot_done
);
    boot_phase_e phase, phase_nx;

    always_comb begin
        phase_nx = phase;
        case (phase)
            BG_ARM:  if (!ctl0_s) phase_nx = BG_LOW;
            BG_LOW:  if (ctl0_s)  phase_nx = BG_HIGH;
            BG_HIGH: if (!ctl0_s) phase_nx = BG_DONE;
            default: phase_nx = BG_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= BG_ARM;
        else     phase <= phase_nx;
    end

    assign boot_done = (phase == BG_DONE);
endmodule

// File: rtl/tcx_aux_timer.sv
module tcx_aux_timer
    import tcx_pkg::*;
#(
    parameter int OPEN_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl1_s,
    input  logic       flip_s,
    output logic [1:0] aux_map
);
    localparam int               CNT_W   = $clog2(OPEN_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(OPEN_CYCLES);

    logic [CNT_W-1:0] low_cnt;
    logic             expired;

    assign expired = (low_cnt == CNT_END);

    always_ff @(posedge clk) begin
        if (rst || ctl1_s)  low_cnt <= '0;
        else if (!expired)  low_cnt <= low_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          aux_map <= AUX_OPEN;
        else if (ctl1_s)  aux_map <= flip_s ? AUX_CROSSED : AUX_STRAIGHT;
        else if (expired) aux_map <= AUX_OPEN;
    end
endmodule

// File: rtl/tcx_route_reg.sv
module tcx_route_reg
    import tcx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  route_t route_d,
    output route_t route_q
);
    localparam route_t RESET_ROUTE = decode_route(MODE_USB, 1'b0);

    logic [NUM_CONN_LANES-1:0][LANE_CODE_W-1:0] lane_q;

    for (genvar g = 0; g < NUM_CONN_LANES; g++) begin : g_lane
        logic [LANE_CODE_W-1:0] sel_q;
        always_ff @(posedge clk) begin
            if (rst) sel_q <= RESET_ROUTE.lane[g];
            else     sel_q <= route_d.lane[g];
        end
        assign lane_q[g] = sel_q;
    end

    usrx_src_e usrx_q;
    logic      pwrdn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            usrx_q  <= RESET_ROUTE.usrx;
            pwrdn_q <= RESET_ROUTE.pwrdn;
        end else begin
            usrx_q  <= route_d.usrx;
            pwrdn_q <= route_d.pwrdn;
        end
    end

    always_comb begin
        route_q.lane  = lane_q;
        route_q.usrx  = usrx_q;
        route_q.pwrdn = pwrdn_q;
    end
endmodule

// File: rtl/tcx_lane_router.sv
module tcx_lane_router
    import tcx_pkg::*;
#(
    parameter int AUX_OPEN_CYCLES = 2000,
    parameter int SYNC_STAGES     = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl1_i,
    input  logic       ctl0_i,
    input  logic       flip_i,
    output logic [2:0] tx1_sel_o,
    output logic [2:0] rx1_sel_o,
    output logic [2:0] tx2_sel_o,
    output logic [2:0] rx2_sel_o,
    output logic [1:0] usrx_sel_o,
    output logic [1:0] aux_sel_o,
    output logic       pwrdn_o
);
    logic [2:0] pins_s;
    logic       ctl1_s, ctl0_s, flip_s;
    logic       boot_done;
    xbar_mode_e mode_sel;
    route_t     route_d, route_q;

    tcx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ctl1_i, ctl0_i, flip_i}),
        .dout (pins_s)
    );

    assign {ctl1_s, ctl0_s, flip_s} = pins_s;

    tcx_boot_gate u_boot (
        .clk       (clk),
        .rst       (rst),
        .ctl0_s    (ctl0_s),
        .boot_done (boot_done)
    );

    assign mode_sel = boot_done ? xbar_mode_e'({ctl1_s, ctl0_s}) : MODE_USB;
    assign route_d  = decode_route(mode_sel, flip_s);

    tcx_route_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .route_d (route_d),
        .route_q (route_q)
    );

    tcx_aux_timer #(.OPEN_CYCLES(AUX_OPEN_CYCLES)) u_aux (
        .clk     (clk),
        .rst     (rst),
        .ctl1_s  (ctl1_s),
        .flip_s  (flip_s),
        .aux_map (aux_sel_o)
    );

    assign tx1_sel_o  = route_q.lane[LANE_TX1];
    assign rx1_sel_o  = route_q.lane[LANE_RX1];
    assign tx2_sel_o  = route_q.lane[LANE_TX2];
    assign rx2_sel_o  = route_q.lane[LANE_RX2];
    assign usrx_sel_o = route_q.usrx;
    assign pwrdn_o    = route_q.pwrdn;
endmodule

// File: rtl/tcx_lane_router_chk.sv
module tcx_lane_router_chk #(
    parameter int OPEN_CYCLES = 2000
) (
    input logic       clk,
    input logic       rst,
    input logic       ctl1_s,
    input logic       flip_s,
    input logic       boot_done,
    input logic [2:0] tx1_sel_o,
    input logic [2:0] rx1_sel_o,
    input logic [2:0] tx2_sel_o,
    input logic [2:0] rx2_sel_o,
    input logic [1:0] usrx_sel_o,
    input logic [1:0] aux_sel_o,
    input logic       pwrdn_o
);
    localparam int RUN_W = $clog2(OPEN_CYCLES + 2);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(OPEN_CYCLES + 1);
    localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(OPEN_CYCLES);

    logic [RUN_W-1:0] low_run;
    always_ff @(posedge clk) begin
        if (rst || ctl1_s)        low_run <= '0;
        else if (low_run != RUN_MAX) low_run <= low_run + 1'b1;
    end

    AST_PWRDN_ISOLATES: assert property (@(posedge clk) disable iff (rst)
        pwrdn_o |-> (tx1_sel_o == 3'd0 && rx1_sel_o == 3'd0 && tx2_sel_o == 3'd0 && rx2_sel_o == 3'd0 && usrx_sel_o == 2'd0)); // R2

    AST_LEGAL_CODES: assert property (@(posedge clk) disable iff (rst)
        (tx1_sel_o[2:1] != 2'b01 && tx2_sel_o[2:1] != 2'b01 && rx1_sel_o[2:1] != 2'b01 && rx2_sel_o[2:1] != 2'b01
         && rx1_sel_o != 3'd1 && rx2_sel_o != 3'd1 && usrx_sel_o != 2'd3)); // R1

    AST_USB_SAME_SIDE: assert property (@(posedge clk) disable iff (rst)
        (usrx_sel_o == 2'd1 |-> tx1_sel_o == 3'd1) and (usrx_sel_o == 2'd2 |-> tx2_sel_o == 3'd1)); // R3

    AST_DP_NO_DUP: assert property (@(posedge clk) disable iff (rst)
        (tx1_sel_o[2] |-> (tx1_sel_o != rx1_sel_o && tx1_sel_o != tx2_sel_o && tx1_sel_o != rx2_sel_o))
        and (rx2_sel_o[2] |-> (rx2_sel_o != rx1_sel_o && rx2_sel_o != tx2_sel_o))
        and (rx1_sel_o[2] |-> rx1_sel_o != tx2_sel_o)); // R4

    AST_FORCED_USB: assert property (@(posedge clk) disable iff (rst)
        !boot_done |=> (!pwrdn_o && !tx1_sel_o[2] && !rx1_sel_o[2] && !tx2_sel_o[2] && !rx2_sel_o[2])); // R8

    AST_AUX_FOLLOWS_HIGH: assert property (@(posedge clk) disable iff (rst)
        ctl1_s |=> aux_sel_o == ($past(flip_s) ? 2'd2 : 2'd1)); // R6

    AST_AUX_NO_EARLY_OPEN: assert property (@(posedge clk) disable iff (rst)
        (aux_sel_o == 2'd0 && $past(aux_sel_o) != 2'd0) |-> low_run > RUN_LIM); // R7
endmodule

bind tcx_lane_router tcx_lane_router_chk #(.OPEN_CYCLES(AUX_OPEN_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl1_s     (ctl1_s),
    .flip_s     (flip_s),
    .boot_done  (boot_done),
    .tx1_sel_o  (tx1_sel_o),
    .rx1_sel_o  (rx1_sel_o),
    .tx2_sel_o  (tx2_sel_o),
    .rx2_sel_o  (rx2_sel_o),
    .usrx_sel_o (usrx_sel_o),
    .aux_sel_o  (aux_sel_o),
    .pwrdn_o    (pwrdn_o)
);

// File: tb/tcx_lane_router_bench.sv
`timescale 1ns/1ps
module tcx_lane_router_bench;
    localparam int LIMIT  = 2000;
    localparam int SETTLE = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl1_i = 1'b0, ctl0_i = 1'b0, flip_i = 1'b0;
    logic [2:0] tx1_sel_o, rx1_sel_o, tx2_sel_o, rx2_sel_o;
    logic [1:0] usrx_sel_o, aux_sel_o;
    logic       pwrdn_o;

    always #4 clk = ~clk;

    tcx_lane_router #(.AUX_OPEN_CYCLES(LIMIT)) u_tcx_lane_router (
        .clk(clk), .rst(rst), .ctl1_i(ctl1_i), .ctl0_i(ctl0_i), .flip_i(flip_i),
        .tx1_sel_o(tx1_sel_o), .rx1_sel_o(rx1_sel_o), .tx2_sel_o(tx2_sel_o), .rx2_sel_o(rx2_sel_o),
        .usrx_sel_o(usrx_sel_o), .aux_sel_o(aux_sel_o), .pwrdn_o(pwrdn_o)
    );

    typedef struct {
        logic [2:0] tx1, rx1, tx2, rx2;
        logic [1:0] usrx, aux;
        logic       pwrdn;
        string      req;
        string      aux_req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    // bench-side view of the pin history
    int         stage;
    int         low_run;
    logic [1:0] aux_exp;

    function automatic exp_t model(bit c1, bit c0, bit fl, bit released);
        exp_t e;
        bit [1:0] m;
        e.tx1 = 0; e.rx1 = 0; e.tx2 = 0; e.rx2 = 0; e.usrx = 0; e.pwrdn = 0;
        e.aux = aux_exp;
        e.aux_req = c1 ? "R6" : "R7";
        m = released ? {c1, c0} : 2'b01;
        case (m)
            2'b00: begin e.pwrdn = 1; e.req = "R2"; end
            2'b01: begin
                e.req = "R3";
                if (!fl) begin e.tx1 = 1; e.usrx = 1; end
                else     begin e.tx2 = 1; e.usrx = 2; end
            end
            2'b10: begin
                e.req = "R4";
                if (!fl) begin e.rx2 = 4; e.tx2 = 5; e.tx1 = 6; e.rx1 = 7; end
                else     begin e.rx1 = 4; e.tx1 = 5; e.tx2 = 6; e.rx2 = 7; end
            end
            default: begin
                e.req = "R5";
                if (!fl) begin e.tx1 = 1; e.usrx = 1; e.rx2 = 4; e.tx2 = 5; end
                else     begin e.tx2 = 1; e.usrx = 2; e.rx1 = 4; e.tx1 = 5; end
            end
        endcase
        if (!released) e.req = "R8";
        return e;
    endfunction

    task automatic drive(input bit c1, input bit c0, input bit fl, input int hold);
        @(negedge clk);
        ctl1_i = c1; ctl0_i = c0; flip_i = fl;
        if (stage == 1 && c0)       stage = 2;
        else if (stage == 2 && !c0) stage = 3;
        if (c1) begin
            low_run = 0;
            aux_exp = fl ? 2'd2 : 2'd1;
        end else begin
            low_run += hold;
            if (low_run > LIMIT + 3) aux_exp = 2'd0;
        end
        repeat (hold - 1) @(negedge clk);
        q.push_back(model(c1, c0, fl, stage == 3));
    endtask

    task automatic reset_dut(input bit c1, input bit c0, input bit fl);
        exp_t e;
        @(negedge clk);
        rst = 1'b1; ctl1_i = c1; ctl0_i = c0; flip_i = fl;
        repeat (4) @(negedge clk);
        e.tx1 = 1; e.rx1 = 0; e.tx2 = 0; e.rx2 = 0; e.usrx = 1; e.aux = 0; e.pwrdn = 0;
        e.req = "R9"; e.aux_req = "R9";
        q.push_back(e);
        #1;
        rst = 1'b0;
        stage = 1; low_run = 0; aux_exp = 2'd0;
    endtask

    task automatic cmp(input string what, input int act, input int exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // monitor: pops expected items and compares with the outputs
    initial begin
        exp_t e;
        forever begin
            wait (q.size() != 0);
            e = q.pop_front();
            cmp("tx1",   int'(tx1_sel_o),  int'(e.tx1),   e.req);
            cmp("rx1",   int'(rx1_sel_o),  int'(e.rx1),   e.req);
            cmp("tx2",   int'(tx2_sel_o),  int'(e.tx2),   e.req);
            cmp("rx2",   int'(rx2_sel_o),  int'(e.rx2),   e.req);
            cmp("usrx",  int'(usrx_sel_o), int'(e.usrx),  e.req);
            cmp("pwrdn", int'(pwrdn_o),    int'(e.pwrdn), e.req);
            cmp("aux",   int'(aux_sel_o),  int'(e.aux),   e.aux_req);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        stage = 1; low_run = 0; aux_exp = 2'd0;
        // R9: reset state, pins asking for four-lane DP with flip
        reset_dut(1'b1, 1'b0, 1'b1);
        // R8: forced USB, orientation still follows flip
        drive(1, 0, 1, SETTLE);
        drive(1, 1, 1, SETTLE);   // R8: pulse only half done
        drive(0, 1, 0, SETTLE);   // R8: still forced, flip low
        drive(0, 0, 0, SETTLE);   // completes low-high-low -> live decode (R2 power-down)
        // R1 R2 R3 R4 R5 R6: every pin combination
        for (int i = 0; i < 8; i++) begin
            drive(i[2], i[1], i[0], SETTLE);
        end
        // R7: low just under the window keeps the mapping
        drive(1, 1, 0, SETTLE);
        drive(0, 1, 0, LIMIT - 20);
        drive(1, 1, 1, SETTLE);
        // R7: low just over the window opens the path
        drive(0, 1, 1, LIMIT + 20);
        drive(0, 0, 1, SETTLE);   // R2 with flip high, AUX stays open
        // R8: a second reset forces USB again, then the pulse releases it
        reset_dut(1'b1, 1'b1, 1'b0);
        drive(1, 1, 0, SETTLE);
        drive(1, 0, 0, SETTLE);   // released -> R4 no flip
        wait (q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule